// File: doc/BRIEF.md
# Multi-Level Vectored Interrupt Controller

This block arbitrates among 82 interrupt request lines for a small processor core. Software gives each line one of four priority levels through a synchronous write port. Two low-numbered lines are tied to a fixed level that writes cannot change. A set of per-level encoders finds the lowest-numbered active line at each level. A selector then keeps the highest level that is permitted both by the core's two-bit mask and by the nesting state. The winner is presented to the core as a registered vector address, made of a software base value with the winning line number appended to it.

The core signals that it has taken a vector by pulsing `irq_ack`, and that a handler has finished by pulsing `irq_done`. From these pulses the block tracks which levels are in service and reports the deepest one on `cur_lvl`. While a handler runs, only requests of a strictly higher level are offered to the core. A separate registered wake output goes high whenever any request passes the core mask, whatever the nesting state. It is meant to restart stopped clocks.

Top module: `vec_intc`

## Requirements
- R1: Each source has a 2-bit level register. Source s sits in write word s/8 at bits [2k+1:2k], where k = s%8. Word addresses run from 0 to 10, and the 16-bit vector base register is at address 11. All of these clear to zero on reset, so every programmable source starts at level 0.
- R2: Sources 0 and 1 always have level 3. Writes to their bit fields have no effect.
- R3: When several active requests share the winning level, the request with the smallest source index is selected.
- R4: Level 3 outranks level 2, level 2 outranks level 1, and level 1 outranks level 0. The selected request comes from the highest permitted level that has an active request.
- R5: A request is permitted by the core mask only when its level is greater than or equal to the mask value. A mask of 0 admits all levels, and a mask of 3 admits only level 3.
- R6: `irq_vec` is the 23-bit concatenation {base[15:0], source[6:0]} of the selected request.
- R7: `irq_valid`, `irq_vec` and `irq_lvl` are registered. They reflect the inputs present before the previous rising edge. When no request is permitted, all three are zero.
- R8: An `irq_ack` pulse while `irq_valid` is high marks `irq_lvl` as in service. `cur_lvl` reads 0 when no level is in service. Otherwise it reads the highest in-service level plus one, saturating at 3.
- R9: While any level is in service, only requests whose level is strictly above the highest in-service level can become valid.
- R10: An `irq_done` pulse removes the highest in-service level. `irq_ack` while `irq_valid` is low, and `irq_done` while nothing is in service, leave `cur_lvl` unchanged.
- R11: `irq_wake` is registered. It is high when any active request has a level greater than or equal to the core mask, regardless of nesting.
- R12: During reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 82 | Level-sensitive request lines, bit s = source s |
| core_mask | input | 2 | Minimum level the core currently accepts |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 16 | Register write data |
| irq_ack | input | 1 | Core took the presented vector |
| irq_done | input | 1 | Core finished the innermost handler |
| irq_valid | output | 1 | A permitted request is presented |
| irq_vec | output | 23 | Vector address {base, source} |
| irq_lvl | output | 2 | Level of the presented request |
| cur_lvl | output | 2 | Nesting code: 0 idle, else top in-service level + 1 (max 3) |
| irq_wake | output | 1 | Request pending above the core mask |

## Verification
The hardest state to reach from the ports is a stack of three in-service levels. In that state every pending request is blocked by nesting, yet `irq_wake` stays high. The stimulus builds the stack by raising requests of rising level one at a time and acknowledging each one while it is presented. It then unwinds the stack with `irq_done` pulses, checking after each pulse which requests become eligible again. Fixed-level sources are checked by writing a different level into their fields and then racing them against a programmed level-3 source with a higher index.

// File: rtl/intc_pkg.sv
package intc_pkg;
   localparam int LVL_W   = 2;
   localparam int NUM_LVL = 1 << LVL_W;
   typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/intc_prio_regs.sv
module intc_prio_regs
   import intc_pkg::*;
#(
   parameter int NUM_SRC   = 82,
   parameter int DATA_W    = 16,
   parameter int BASE_W    = 16,
   parameter int ADDR_W    = 4,
   parameter int FIXED_CNT = 2,
   parameter int FIXED_LVL = 3
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [DATA_W-1:0]         wdata,
   output lvl_t [NUM_SRC-1:0]        src_lvl,
   output logic [BASE_W-1:0]         base
);
   localparam int SPW       = DATA_W / LVL_W;
   localparam int NWORDS    = (NUM_SRC + SPW - 1) / SPW;
   localparam int BASE_ADDR = NWORDS;

   if (BASE_ADDR >= (1 << ADDR_W)) begin : g_addr_chk
      $error("ADDR_W too narrow for the register map");
   end
   if (BASE_W > DATA_W) begin : g_base_chk
      $error("BASE_W must not exceed DATA_W");
   end
   if (FIXED_LVL >= NUM_LVL || FIXED_CNT > NUM_SRC) begin : g_fix_chk
      $error("fixed-level parameters out of range");
   end

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      localparam int WORD = s / SPW;
      localparam int SLOT = s % SPW;
      if (s < FIXED_CNT) begin : g_fixed
         assign src_lvl[s] = lvl_t'(FIXED_LVL);
      end else begin : g_prog
         lvl_t lvl_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lvl_q <= '0;
            end else if (we && addr == ADDR_W'(WORD)) begin
               lvl_q <= wdata[SLOT*LVL_W +: LVL_W];
            end
         end
         assign src_lvl[s] = lvl_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base <= '0;
      end else if (we && addr == ADDR_W'(BASE_ADDR)) begin
         base <= wdata[BASE_W-1:0];
      end
   end
endmodule

// File: rtl/intc_level_arb.sv
module intc_level_arb
   import intc_pkg::*;
#(
   parameter int NUM_SRC = 82,
   localparam int ID_W   = $clog2(NUM_SRC)
)(
   input  logic [NUM_SRC-1:0]            req,
   input  lvl_t [NUM_SRC-1:0]            src_lvl,
   output logic [NUM_LVL-1:0]            lvl_any,
   output logic [NUM_LVL-1:0][ID_W-1:0]  lvl_id
);
   for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
      logic [NUM_SRC-1:0] hit_vec;
      logic [ID_W-1:0]    first_id;

      always_comb begin
         for (int s = 0; s < NUM_SRC; s++) begin
            hit_vec[s] = req[s] && (src_lvl[s] == lvl_t'(l));
         end
      end

      // lowest index wins: scan downward so the last hit kept is the smallest
      always_comb begin
         first_id = '0;
         for (int s = NUM_SRC - 1; s >= 0; s--) begin
            if (hit_vec[s]) begin
               first_id = ID_W'(s);
            end
         end
      end

      assign lvl_any[l] = |hit_vec;
      assign lvl_id[l]  = first_id;
   end
endmodule

// File: rtl/intc_sel.sv
module intc_sel
   import intc_pkg::*;
#(
   parameter int ID_W = 7
)(
   input  logic [NUM_LVL-1:0]            lvl_any,
   input  logic [NUM_LVL-1:0][ID_W-1:0]  lvl_id,
   input  lvl_t                          core_mask,
   input  logic [NUM_LVL-1:0]            in_svc,
   output logic                          sel_valid,
   output lvl_t                          sel_lvl,
   output logic [ID_W-1:0]               sel_id,
   output logic                          wake
);
   lvl_t               svc_top;
   logic [NUM_LVL-1:0] mask_ok;
   logic [NUM_LVL-1:0] nest_ok;

   always_comb begin
      svc_top = '0;
      for (int l = 0; l < NUM_LVL; l++) begin
         if (in_svc[l]) begin
            svc_top = lvl_t'(l);
         end
      end
   end

   for (genvar l = 0; l < NUM_LVL; l++) begin : g_perm
      assign mask_ok[l] = lvl_t'(l) >= core_mask;
      assign nest_ok[l] = (in_svc == '0) || (lvl_t'(l) > svc_top);
   end

   always_comb begin
      sel_valid = 1'b0;
      sel_lvl   = '0;
      sel_id    = '0;
      for (int l = 0; l < NUM_LVL; l++) begin
         if (lvl_any[l] && mask_ok[l] && nest_ok[l]) begin
            sel_valid = 1'b1;
            sel_lvl   = lvl_t'(l);
            sel_id    = lvl_id[l];
         end
      end
   end

   assign wake = |(lvl_any & mask_ok);
endmodule

// File: rtl/intc_nest.sv
module intc_nest
   import intc_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ack,
   input  logic                done,
   input  logic                pres_valid,
   input  lvl_t                pres_lvl,
   output logic [NUM_LVL-1:0]  in_svc,
   output lvl_t                cur_code
);
   logic [NUM_LVL-1:0] top_oh;
   logic [NUM_LVL-1:0] clr_vec;
   logic [NUM_LVL-1:0] set_vec;
   int unsigned        top_idx;

   always_comb begin
      top_oh  = '0;
      top_idx = 0;
      for (int l = 0; l < NUM_LVL; l++) begin
         if (in_svc[l]) begin
            top_oh  = '0;
            top_oh[l] = 1'b1;
            top_idx = l;
         end
      end
   end

   assign clr_vec = done ? top_oh : '0;
   assign set_vec = (ack && pres_valid) ? (NUM_LVL'(1) << pres_lvl) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_svc <= '0;
      end else begin
         in_svc <= (in_svc & ~clr_vec) | set_vec;
      end
   end

   always_comb begin
      if (in_svc == '0) begin
         cur_code = '0;
      end else if (top_idx + 1 >= NUM_LVL) begin
         cur_code = lvl_t'(NUM_LVL - 1);
      end else begin
         cur_code = lvl_t'(top_idx + 1);
      end
   end
endmodule

// File: rtl/vec_intc.sv
module vec_intc
   import intc_pkg::*;
#(
   parameter int NUM_SRC   = 82,
   parameter int DATA_W    = 16,
   parameter int BASE_W    = 16,
   parameter int ADDR_W    = 4,
   parameter int FIXED_CNT = 2,
   parameter int FIXED_LVL = 3,
   localparam int ID_W     = $clog2(NUM_SRC),
   localparam int VEC_W    = BASE_W + ID_W
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_SRC-1:0]  irq_req,
   input  logic [LVL_W-1:0]    core_mask,
   input  logic                reg_we,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0]   reg_wdata,
   input  logic                irq_ack,
   input  logic                irq_done,
   output logic                irq_valid,
   output logic [VEC_W-1:0]    irq_vec,
   output logic [LVL_W-1:0]    irq_lvl,
   output logic [LVL_W-1:0]    cur_lvl,
   output logic                irq_wake
);
   if (NUM_SRC < 2) begin : g_src_chk
      $error("NUM_SRC must be at least 2");
   end

   lvl_t [NUM_SRC-1:0]            src_lvl;
   logic [BASE_W-1:0]             base;
   logic [NUM_LVL-1:0]            lvl_any;
   logic [NUM_LVL-1:0][ID_W-1:0]  lvl_id;
   logic [NUM_LVL-1:0]            in_svc;
   logic                          sel_valid;
   lvl_t                          sel_lvl;
   logic [ID_W-1:0]               sel_id;
   logic                          sel_wake;

   intc_prio_regs #(
      .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .BASE_W(BASE_W),
      .ADDR_W(ADDR_W), .FIXED_CNT(FIXED_CNT), .FIXED_LVL(FIXED_LVL)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
      .wdata(reg_wdata), .src_lvl(src_lvl), .base(base)
   );

   intc_level_arb #(.NUM_SRC(NUM_SRC)) u_arb (
      .req(irq_req), .src_lvl(src_lvl), .lvl_any(lvl_any), .lvl_id(lvl_id)
   );

   intc_sel #(.ID_W(ID_W)) u_sel (
      .lvl_any(lvl_any), .lvl_id(lvl_id), .core_mask(core_mask),
      .in_svc(in_svc), .sel_valid(sel_valid), .sel_lvl(sel_lvl),
      .sel_id(sel_id), .wake(sel_wake)
   );

   intc_nest u_nest (
      .clk(clk), .rst_n(rst_n), .ack(irq_ack), .done(irq_done),
      .pres_valid(irq_valid), .pres_lvl(irq_lvl),
      .in_svc(in_svc), .cur_code(cur_lvl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_valid <= 1'b0;
         irq_vec   <= '0;
         irq_lvl   <= '0;
         irq_wake  <= 1'b0;
      end else begin
         irq_valid <= sel_valid;
         irq_vec   <= sel_valid ? {base, sel_id} : '0;
         irq_lvl   <= sel_valid ? sel_lvl : '0;
         irq_wake  <= sel_wake;
      end
   end
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
   parameter int NUM_SRC = 82,
   parameter int BASE_W  = 16,
   localparam int ID_W   = $clog2(NUM_SRC),
   localparam int VEC_W  = BASE_W + ID_W
)(
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_SRC-1:0]  irq_req,
   input logic [1:0]          core_mask,
   input logic                irq_ack,
   input logic                irq_valid,
   input logic [VEC_W-1:0]    irq_vec,
   input logic [1:0]          irq_lvl,
   input logic [1:0]          cur_lvl,
   input logic                irq_wake
);
   logic [NUM_SRC-1:0] req_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_d <= '0;
      else        req_d <= irq_req;
   end

   AST_MASK_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> irq_lvl >= $past(core_mask)); // R5
   AST_NEST_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid && $past(cur_lvl) != 2'd0) |-> irq_lvl >= $past(cur_lvl)); // R9
   AST_ID_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> irq_vec[ID_W-1:0] < ID_W'(NUM_SRC)); // R6
   AST_ID_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> req_d[irq_vec[ID_W-1:0]]); // R3
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_valid |-> (irq_vec == '0 && irq_lvl == 2'd0)); // R7
   AST_WAKE_COVER: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> irq_wake); // R11
   AST_SVC_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cur_lvl != 2'd0) |-> $past(irq_ack)); // R8
endmodule

bind vec_intc intc_chk #(.NUM_SRC(NUM_SRC), .BASE_W(BASE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .core_mask(core_mask),
   .irq_ack(irq_ack), .irq_valid(irq_valid), .irq_vec(irq_vec),
   .irq_lvl(irq_lvl), .cur_lvl(cur_lvl), .irq_wake(irq_wake)
);

// File: tb/vec_intc_tb.sv
module vec_intc_tb;
   localparam int N = 82;

   typedef struct packed {
      logic [N-1:0] req;
      logic [1:0]   mask;
      logic         valid;
      logic [6:0]   id;
      logic [1:0]   lvl;
   } row_t;

   // levels after programming: s0,s1=3 (fixed) s3=0 s5=1 s7=3 s10=2 s40=2 s81=1
   localparam row_t TAB [13] = '{
      '{ '0,                                   2'd0, 1'b0, 7'd0,  2'd0 }, // R7 none
      '{ (N'(1) << 3),                         2'd0, 1'b1, 7'd3,  2'd0 }, // R5
      '{ (N'(1) << 3),                         2'd1, 1'b0, 7'd0,  2'd0 }, // R5 masked
      '{ (N'(1) << 3) | (N'(1) << 5),          2'd0, 1'b1, 7'd5,  2'd1 }, // R4
      '{ (N'(1) << 81) | (N'(1) << 5),         2'd0, 1'b1, 7'd5,  2'd1 }, // R3
      '{ (N'(1) << 81) | (N'(1) << 10),        2'd1, 1'b1, 7'd10, 2'd2 }, // R4
      '{ (N'(1) << 40) | (N'(1) << 10),        2'd0, 1'b1, 7'd10, 2'd2 }, // R3
      '{ (N'(1) << 40) | (N'(1) << 7),         2'd2, 1'b1, 7'd7,  2'd3 }, // R4
      '{ (N'(1) << 0) | (N'(1) << 7),          2'd3, 1'b1, 7'd0,  2'd3 }, // R2
      '{ (N'(1) << 5),                         2'd2, 1'b0, 7'd0,  2'd0 }, // R5
      '{ (N'(1) << 40),                        2'd3, 1'b0, 7'd0,  2'd0 }, // R5
      '{ (N'(1) << 81) | (N'(1) << 3),         2'd1, 1'b1, 7'd81, 2'd1 }, // R5
      '{ (N'(1) << 3) | (N'(1) << 40) | (N'(1) << 81), 2'd0, 1'b1, 7'd40, 2'd2 } // R4
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  irq_req = '0;
   logic [1:0]    core_mask = '0;
   logic          reg_we = 1'b0;
   logic [3:0]    reg_addr = '0;
   logic [15:0]   reg_wdata = '0;
   logic          irq_ack = 1'b0;
   logic          irq_done = 1'b0;
   logic          irq_valid;
   logic [22:0]   irq_vec;
   logic [1:0]    irq_lvl;
   logic [1:0]    cur_lvl;
   logic          irq_wake;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   vec_intc u_dut (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .core_mask(core_mask),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .irq_ack(irq_ack), .irq_done(irq_done), .irq_valid(irq_valid),
      .irq_vec(irq_vec), .irq_lvl(irq_lvl), .cur_lvl(cur_lvl), .irq_wake(irq_wake)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(logic [3:0] a, logic [15:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      step();
      reg_we = 1'b0;
   endtask

   task automatic pulse_ack();
      irq_ack = 1'b1; step(); irq_ack = 1'b0;
   endtask

   task automatic pulse_done();
      irq_done = 1'b1; step(); irq_done = 1'b0;
   endtask

   task automatic expect_out(string tag, logic v, logic [6:0] id, logic [1:0] l);
      chk({tag, " valid"}, 32'(irq_valid), 32'(v));
      chk({tag, " vec"},   32'(irq_vec), v ? {9'd0, 16'h1234, id} : 32'd0);
      chk({tag, " lvl"},   32'(irq_lvl), v ? 32'(l) : 32'd0);
   endtask

   initial begin
      #2000000;
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R12 reset state
      #23;
      chk("R12 valid", 32'(irq_valid), 0);
      chk("R12 vec",   32'(irq_vec), 0);
      chk("R12 cur",   32'(cur_lvl), 0);
      chk("R12 wake",  32'(irq_wake), 0);
      @(negedge clk);
      rst_n = 1'b1;
      step();

      // R1 defaults: programmable level 0, base 0
      irq_req = N'(1) << 5;
      step();
      chk("R1 default valid", 32'(irq_valid), 1);
      chk("R1 default vec",   32'(irq_vec), 32'd5);
      chk("R1 default lvl",   32'(irq_lvl), 0);
      irq_req = '0;

      // R1 program: word0 s5=1 s7=3 (s0 field=1 tests R2), word1 s10=2, word5 s40=2, word10 s81=1
      wr(4'd0,  16'hC401);
      wr(4'd1,  16'h0020);
      wr(4'd5,  16'h0002);
      wr(4'd10, 16'h0004);
      wr(4'd11, 16'h1234);

      foreach (TAB[i]) begin
         irq_req   = TAB[i].req;
         core_mask = TAB[i].mask;
         step();
         expect_out($sformatf("R7 row%0d", i), TAB[i].valid, TAB[i].id, TAB[i].lvl);
         chk($sformatf("R11 row%0d wake", i), 32'(irq_wake), 32'(TAB[i].valid));
      end

      // nesting sequence
      core_mask = 2'd0;
      irq_req = N'(1) << 5;
      step();
      expect_out("R8 pre", 1'b1, 7'd5, 2'd1);
      pulse_ack();
      chk("R8 cur after ack lvl1", 32'(cur_lvl), 32'd2);
      irq_req = (N'(1) << 5) | (N'(1) << 3);
      step();
      expect_out("R9 blocked", 1'b0, 7'd0, 2'd0);
      chk("R11 wake while blocked", 32'(irq_wake), 1);
      irq_req = (N'(1) << 5) | (N'(1) << 3) | (N'(1) << 10);
      step();
      expect_out("R9 preempt lvl2", 1'b1, 7'd10, 2'd2);
      pulse_ack();
      chk("R8 cur after ack lvl2", 32'(cur_lvl), 32'd3);
      irq_req = (N'(1) << 5) | (N'(1) << 3) | (N'(1) << 10) | (N'(1) << 7);
      step();
      expect_out("R9 preempt lvl3", 1'b1, 7'd7, 2'd3);
      pulse_ack();
      chk("R8 cur saturate", 32'(cur_lvl), 32'd3);
      step();
      expect_out("R9 lvl3 blocks all", 1'b0, 7'd0, 2'd0);
      chk("R11 wake under lvl3", 32'(irq_wake), 1);
      pulse_done();
      chk("R10 cur after done1", 32'(cur_lvl), 32'd3);
      step();
      expect_out("R10 lvl3 eligible", 1'b1, 7'd7, 2'd3);
      pulse_done();
      chk("R10 cur after done2", 32'(cur_lvl), 32'd2);
      pulse_done();
      chk("R10 cur after done3", 32'(cur_lvl), 32'd0);
      pulse_done();
      chk("R10 done idle ignored", 32'(cur_lvl), 32'd0);
      irq_req = '0;
      step();
      step();
      expect_out("R7 cleared", 1'b0, 7'd0, 2'd0);
      pulse_ack();
      chk("R10 ack without valid", 32'(cur_lvl), 32'd0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule